// File: doc/BRIEF.md
# Lowest-Priority Interrupt Delivery Arbiter

When an interrupt is delivered in lowest-priority mode, this block decides which of several processors receives it. A request carries an 8-bit vector and a mask of the processors that may take it. Each processor reports four things: a task priority value, the vector it is currently servicing with a valid flag, a focus-check enable, and an enable that allows its task priority to be stored. From these inputs the arbiter works out each processor's effective priority. It then removes every processor whose task priority class blocks the vector's class, and grants the interrupt to the least busy processor that remains.

Focus checking can override that choice. A processor that is already servicing the same vector, and has focus checking enabled, keeps the interrupt. If no processor in the mask can take the interrupt, the arbiter holds the request, raises a pending flag and evaluates it again every cycle. The request leaves that state only by being granted or by being cancelled.

Top module: `lowpri_arbiter`

## Requirements
- R1: The effective priority of a processor is the larger of two values: its stored task priority, and its in-service vector with bits 3:0 cleared. The in-service vector counts only while its valid flag is set, and counts as 0x00 otherwise. Among eligible processors, the one with the numerically lowest effective priority receives the grant.
- R2: A processor is eligible only when two conditions hold. Its bit in the destination mask is set, and the request vector's bits 7:4 are strictly greater than its stored task priority bits 7:4. An equal class blocks.
- R3: A stored task priority between 0x00 and 0x0F blocks no vector whose bits 7:4 are nonzero, but it still takes part in the lowest-priority comparison.
- R4: When eligible processors tie on effective priority, the lowest processor index wins.
- R5: An eligible processor wins regardless of the priority comparison when its focus enable is set, its in-service flag is valid, and its in-service vector equals the request vector. If several processors match this way, the lowest index wins.
- R6: A processor's task priority is stored on a clock edge only while its update enable is high. Otherwise the last stored value is kept. All per-processor inputs are registered and take effect one cycle after they are driven.
- R7: While a request is held and no processor is eligible, pending_o is high and no grant is given. The request is evaluated again every cycle. It is granted on the edge after a processor becomes eligible.
- R8: A request sampled while the arbiter is idle is evaluated in the next cycle. If a processor is eligible, grant_o shows exactly one bit, set on the edge after capture, for exactly one cycle. A request presented while another request is held is ignored.
- R9: A cancel while a request is held drops that request without a grant, even when a processor is eligible in the same cycle.
- R10: Reset clears every stored task priority to 0x00, every in-service valid flag, grant_o and pending_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Interrupt request strobe |
| req_vector_i | input | 8 | Request vector |
| req_dest_i | input | N_CPU | Mask of processors that may take the request |
| req_cancel_i | input | 1 | Drops the held request |
| tpr_i | input | N_CPU x 8 | Reported task priority for each processor |
| tpr_upd_en_i | input | N_CPU | Per-processor task priority store enable |
| isv_vector_i | input | N_CPU x 8 | Highest in-service vector for each processor |
| isv_valid_i | input | N_CPU | In-service vector valid for each processor |
| focus_en_i | input | N_CPU | Per-processor focus-check enable |
| grant_o | output | N_CPU | One-hot grant, one cycle |
| pending_o | output | 1 | A request is held and no processor is eligible |

## Verification
Two resolutions can fall in the same cycle, and the bench provokes both. In the first, a focus match and a lower effective priority on another processor are present together. The bench sweeps pseudo-random vectors, classes and in-service states with the in-service vector often forced equal to the request. The chosen index is then compared with a model that applies the focus override ahead of the priority comparison. In the second, a task priority update lands while a request is pending. Here the bench checks that the grant appears on the edge after the stored class stops blocking. Separately, it raises a cancel in the cycle a processor becomes eligible and checks that no grant appears.

// File: rtl/lp_arb_pkg.sv
package lp_arb_pkg;
  typedef logic [7:0] prio_t;
  typedef logic [3:0] pclass_t;

  function automatic prio_t class_floor(input prio_t v);
    return {v[7:4], 4'h0};
  endfunction
endpackage

// File: rtl/lp_cpu_eval.sv
module lp_cpu_eval
  import lp_arb_pkg::*;
(
  input  prio_t tpr_i,
  input  prio_t isv_i,
  input  logic  isv_vld_i,
  input  logic  focus_en_i,
  input  logic  dest_i,
  input  prio_t vec_i,
  output prio_t eff_o,
  output logic  elig_o,
  output logic  focus_o
);
  prio_t isv_floor;

  always_comb begin
    isv_floor = isv_vld_i ? class_floor(isv_i) : '0;
    eff_o     = (isv_floor > tpr_i) ? isv_floor : tpr_i;
    // equal class blocks
    elig_o    = dest_i && (pclass_t'(vec_i[7:4]) > pclass_t'(tpr_i[7:4]));
    focus_o   = elig_o && focus_en_i && isv_vld_i && (isv_i == vec_i);
  end
endmodule

// File: rtl/lp_pick.sv
module lp_pick
  import lp_arb_pkg::*;
#(
  parameter int N_CPU = 4
) (
  input  logic [N_CPU-1:0][7:0] eff_i,
  input  logic [N_CPU-1:0]      elig_i,
  input  logic [N_CPU-1:0]      focus_i,
  output logic [N_CPU-1:0]      sel_o,
  output logic                  any_o
);
  prio_t best;
  logic  found;

  always_comb begin
    sel_o = '0;
    best  = '1;
    found = 1'b0;
    any_o = |elig_i;
    for (int i = 0; i < N_CPU; i++) begin
      if (|focus_i) begin
        if (focus_i[i] && !found) begin
          sel_o    = '0;
          sel_o[i] = 1'b1;
          found    = 1'b1;
        end
      end else if (elig_i[i] && (!found || eff_i[i] < best)) begin
        // strict compare keeps the lowest index on ties
        sel_o    = '0;
        sel_o[i] = 1'b1;
        best     = eff_i[i];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lowpri_arbiter.sv
module lowpri_arbiter
  import lp_arb_pkg::*;
#(
  parameter int N_CPU = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [7:0]            req_vector_i,
  input  logic [N_CPU-1:0]      req_dest_i,
  input  logic                  req_cancel_i,
  input  logic [N_CPU-1:0][7:0] tpr_i,
  input  logic [N_CPU-1:0]      tpr_upd_en_i,
  input  logic [N_CPU-1:0][7:0] isv_vector_i,
  input  logic [N_CPU-1:0]      isv_valid_i,
  input  logic [N_CPU-1:0]      focus_en_i,
  output logic [N_CPU-1:0]      grant_o,
  output logic                  pending_o
);
  initial begin
    assert (N_CPU >= 2 && N_CPU <= 8) else $error("N_CPU out of range");
  end

  logic [N_CPU-1:0][7:0] tpr_q, isv_q, eff;
  logic [N_CPU-1:0]      isv_vld_q, foc_q, elig, fmatch, sel;
  logic                  any_elig;
  logic                  hold_q;
  prio_t                 vec_q;
  logic [N_CPU-1:0]      dest_q, grant_q;

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tpr_q[g]     <= '0;
        isv_q[g]     <= '0;
        isv_vld_q[g] <= 1'b0;
        foc_q[g]     <= 1'b0;
      end else begin
        if (tpr_upd_en_i[g]) tpr_q[g] <= tpr_i[g];
        isv_q[g]     <= isv_vector_i[g];
        isv_vld_q[g] <= isv_valid_i[g];
        foc_q[g]     <= focus_en_i[g];
      end
    end

    lp_cpu_eval u_eval (
      .tpr_i      (tpr_q[g]),
      .isv_i      (isv_q[g]),
      .isv_vld_i  (isv_vld_q[g]),
      .focus_en_i (foc_q[g]),
      .dest_i     (dest_q[g]),
      .vec_i      (vec_q),
      .eff_o      (eff[g]),
      .elig_o     (elig[g]),
      .focus_o    (fmatch[g])
    );

    p_tpr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tpr_upd_en_i[g] |=> $stable(tpr_q[g]));
  end

  lp_pick #(.N_CPU(N_CPU)) u_pick (
    .eff_i   (eff),
    .elig_i  (elig),
    .focus_i (fmatch),
    .sel_o   (sel),
    .any_o   (any_elig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b0;
      vec_q   <= '0;
      dest_q  <= '0;
      grant_q <= '0;
    end else begin
      grant_q <= '0;
      if (hold_q) begin
        if (req_cancel_i) begin
          hold_q <= 1'b0;
        end else if (any_elig) begin
          grant_q <= sel;
          hold_q  <= 1'b0;
        end
      end else if (req_valid_i) begin
        hold_q <= 1'b1;
        vec_q  <= req_vector_i;
        dest_q <= req_dest_i;
      end
    end
  end

  assign grant_o   = grant_q;
  assign pending_o = hold_q & ~any_elig;

  p_grant_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  p_grant_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |=> (grant_o == '0));
  p_grant_in_dest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |-> ((grant_o & ~$past(dest_q)) == '0));
  p_pending_no_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |=> (grant_o == '0));
  p_cancel_no_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && req_cancel_i) |=> (grant_o == '0));
  p_grant_from_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |-> $past(hold_q));
endmodule

// File: tb/lowpri_arbiter_bench.sv
`timescale 1ns/1ps
module lowpri_arbiter_bench;
  localparam int N = 4;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  req_valid = 1'b0;
  logic [7:0]            req_vector = '0;
  logic [N-1:0]          req_dest = '0;
  logic                  req_cancel = 1'b0;
  logic [N-1:0][7:0]     tpr = '0;
  logic [N-1:0]          tpr_upd = '0;
  logic [N-1:0][7:0]     isv = '0;
  logic [N-1:0]          isv_vld = '0;
  logic [N-1:0]          foc = '0;
  logic [N-1:0]          grant;
  logic                  pending;

  int checks = 0;
  int errors = 0;
  logic [31:0] lcg = 32'h1234_5678;

  int m_tpr [N];
  int m_isv [N];
  bit m_vld [N];
  bit m_foc [N];

  always #2 clk = ~clk;

  lowpri_arbiter #(.N_CPU(N)) u_lowpri_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_vector_i(req_vector),
    .req_dest_i(req_dest), .req_cancel_i(req_cancel), .tpr_i(tpr), .tpr_upd_en_i(tpr_upd),
    .isv_vector_i(isv), .isv_valid_i(isv_vld), .focus_en_i(foc),
    .grant_o(grant), .pending_o(pending)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nxt();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[30:16]);
  endfunction

  function automatic int model(input int vec, input int dest);
    int g = 0;
    int best = 1000;
    for (int i = 0; i < N; i++) begin
      bit ok = dest[i] && ((vec / 16) > (m_tpr[i] / 16));
      if (g == 0 && ok && m_foc[i] && m_vld[i] && m_isv[i] == vec) g = 1 << i;
    end
    if (g == 0) begin
      for (int i = 0; i < N; i++) begin
        bit ok = dest[i] && ((vec / 16) > (m_tpr[i] / 16));
        int e = m_tpr[i];
        if (m_vld[i] && (m_isv[i] / 16) * 16 > e) e = (m_isv[i] / 16) * 16;
        if (ok && e < best) begin best = e; g = 1 << i; end
      end
    end
    return g;
  endfunction

  task automatic set_cpu(input int i, input int t, input bit up, input int v,
                         input bit vl, input bit f);
    tpr[i] = t[7:0]; tpr_upd[i] = up; isv[i] = v[7:0]; isv_vld[i] = vl; foc[i] = f;
    if (up) m_tpr[i] = t;
    m_isv[i] = v; m_vld[i] = vl; m_foc[i] = f;
  endtask

  // inputs already driven; one negedge lets registers load
  task automatic run_req(input string tag, input int vec, input int dest);
    int exp;
    @(negedge clk);
    tpr_upd = '0;
    exp = model(vec, dest);
    req_valid = 1'b1; req_vector = vec[7:0]; req_dest = dest[N-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " pending"}, int'(pending), int'(exp == 0));
    if (exp != 0) begin
      @(negedge clk);
      check({tag, " grant"}, int'(grant), exp);
      @(negedge clk);
      check({tag, " R8 pulse"}, int'(grant), 0);
    end else begin
      req_cancel = 1'b1;
      @(negedge clk);
      req_cancel = 1'b0;
      check({tag, " R9 cancel grant"}, int'(grant), 0);
      check({tag, " R9 cancel pending"}, int'(pending), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_tpr[i] = 0; m_isv[i] = 0; m_vld[i] = 0; m_foc[i] = 0; end
    repeat (3) @(negedge clk);
    check("R10 reset grant", int'(grant), 0);
    check("R10 reset pending", int'(pending), 0);
    rst_ni = 1'b1;
    // stored tpr must be zero: drive high values without enable
    for (int i = 0; i < N; i++) begin tpr[i] = 8'hFF; tpr_upd[i] = 1'b0; end
    @(negedge clk);
    run_req("R10 tpr cleared", 8'h23, 4'b1111);

    // R1 example: tpr 00 servicing 0x23 -> 0x20, beaten by 0x1F
    set_cpu(0, 8'h00, 1, 8'h23, 1, 0);
    set_cpu(1, 8'h1F, 1, 8'h00, 0, 0);
    set_cpu(2, 8'h30, 1, 8'h00, 0, 0);
    set_cpu(3, 8'h20, 1, 8'h00, 0, 0);
    run_req("R1 isv class", 8'h50, 4'b1111);
    run_req("R3 low tpr no block", 8'h12, 4'b0011);
    // R6: cpu1 reports 0xF0 with enable low -> old 0x1F kept
    set_cpu(1, 8'hF0, 0, 8'h00, 0, 0);
    run_req("R6 update suppressed", 8'h50, 4'b1111);
    // R2: equal class blocks
    run_req("R2 equal class", 8'h35, 4'b0100);
    run_req("R2 dest mask", 8'h90, 4'b1000);
    // R4 ties
    for (int i = 0; i < N; i++) set_cpu(i, 8'h05, 1, 8'h00, 0, 0);
    run_req("R4 tie", 8'h40, 4'b1110);
    // R5 focus overrides lower priority, lowest matching index
    set_cpu(0, 8'h00, 1, 8'h00, 0, 0);
    set_cpu(1, 8'h0A, 1, 8'h77, 1, 1);
    set_cpu(2, 8'h0A, 1, 8'h77, 1, 1);
    set_cpu(3, 8'h0A, 1, 8'h77, 1, 0);
    run_req("R5 focus", 8'h77, 4'b1111);

    // R7 / R8: pending, ignored request, resolution after tpr update
    for (int i = 0; i < N; i++) set_cpu(i, 8'hF0, 1, 8'h00, 0, 0);
    @(negedge clk);
    tpr_upd = '0;
    req_valid = 1'b1; req_vector = 8'h40; req_dest = 4'b0110;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 pending high", int'(pending), 1);
    req_valid = 1'b1; req_vector = 8'hFF; req_dest = 4'b1111;
    set_cpu(3, 8'h00, 1, 8'h00, 0, 0);
    @(negedge clk);
    req_valid = 1'b0; tpr_upd = '0;
    check("R8 held request ignored grant", int'(grant), 0);
    check("R8 held request ignored pending", int'(pending), 1);
    set_cpu(2, 8'h10, 1, 8'h00, 0, 0);
    @(negedge clk);
    tpr_upd = '0;
    check("R7 pending drops after update", int'(pending), 0);
    @(negedge clk);
    check("R7 grant after update", int'(grant), 4'b0100);
    @(negedge clk);
    check("R8 one cycle", int'(grant), 0);

    // R9: cancel in the cycle a processor becomes eligible
    set_cpu(2, 8'hF0, 1, 8'h00, 0, 0);
    @(negedge clk);
    tpr_upd = '0;
    req_valid = 1'b1; req_vector = 8'h40; req_dest = 4'b0100;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 pending before cancel", int'(pending), 1);
    set_cpu(2, 8'h00, 1, 8'h00, 0, 0);
    @(negedge clk);
    tpr_upd = '0;
    req_cancel = 1'b1;
    @(negedge clk);
    req_cancel = 1'b0;
    check("R9 cancel beats grant", int'(grant), 0);
    check("R9 idle after cancel", int'(pending), 0);

    // sweep
    for (int t = 0; t < 1500; t++) begin
      int vec = nxt() % 256;
      int dest = nxt() % 16;
      for (int i = 0; i < N; i++) begin
        int r = nxt();
        int tv = (r % 4 == 0) ? (r / 4) % 16 : (r / 4) % 256;
        int iv = (r % 3 == 0) ? vec : (r / 16) % 256;
        set_cpu(i, tv, (r / 256) % 4 != 0, iv, (r / 1024) % 2 == 1, (r / 2048) % 2 == 1);
      end
      run_req("R1 R2 R3 R4 R5 R6 sweep", vec, dest);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule